// File: doc/BRIEF.md
# Fractional Clock Divider Parameter Search

This block finds the three fields of a fractional clock generator that come closest to a requested bit rate. The generator divides a fixed reference frequency by a mixed number: an integer part A, plus a fraction built from B and C. The achieved rate of a candidate (A, B, C) is `ref*(C+1) / (A*(C+1) + B + 1)`, using truncating integer division. The reference frequency is a parameter. The field widths are parameters too; the defaults are 10, 10 and 12 bits.

A search begins with a one-cycle start strobe that carries the requested rate. The block first takes A from the integer quotient of the reference by the rate. It then walks B upward, and for each B it derives a matching C. It tries C and C+1 and keeps the candidate with the smallest absolute error. The walk ends early on a zero-error hit, or when C no longer fits its field.

All divisions use one shared bit-serial divider, so a search takes a variable number of cycles. When the search finishes, the block raises done and presents the packed control word and the rate that word produces. Both stay valid until the next accepted start.

Top module: `clkdiv_search`

## Requirements
- R1: The first divisor A is the truncated quotient ref / rate. If that quotient exceeds the largest A (2^A_W-1), only the candidate (2^A_W-1, 1, 1) is evaluated and the search ends.
- R2: If the quotient is 0, A becomes 1 and the target rate is replaced by ref for the rest of the search. All error measurements then use ref as the target.
- R3: If rate*A equals ref exactly, only the candidate (A-1, 1, 1) is evaluated and the search ends.
- R4: The achieved rate reported for a candidate (A, B, C) is ref*(C+1) / (A*(C+1)+B+1), truncated.
- R5: The error of a candidate is the absolute difference between its achieved rate and the target. The stored best error starts at all ones, and a candidate replaces the best only if its error is strictly smaller.
- R6: B steps from 0 to 2^B_W-1. For each B, C is computed as (B+1)*rate / (ref - rate*A) - 1. The block evaluates (A, B, C) and then (A, B, C+1), and it stops as soon as either has zero error. If every B is used up, the best candidate found is kept.
- R7: If the computed C is 2^C_W-1 or larger, the walk stops. When B is 0, the block first evaluates (A-1, 1, 1) and stops if that has zero error. It then evaluates (A, B, 2^C_W-1) and stops.
- R8: The control word packs C in bits [C_W-1:0], B in bits [C_W+B_W-1:C_W] and A in the top A_W bits.
- R9: An accepted start clears done at the next clock edge. Done rises when the search finishes and stays high, with the word and rate unchanged, until the next accepted start.
- R10: A start strobe that arrives while a search is running is ignored. The requested rate is sampled only when a start is accepted.
- R11: After reset, done is low and both the control word and the achieved rate are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a search when idle |
| reqRate | input | RATE_W | Requested rate in the same unit as the reference; sampled at start |
| ctrlWord | output | A_W+B_W+C_W | Packed best control word {A, B, C} |
| achievedRate | output | RATE_W | Rate produced by ctrlWord |
| done | output | 1 | High once the search has finished, until the next start |

## Verification
The main function is exercised with requests that each force one exit of the search. Requests below the slowest possible rate separate the A-saturation exit. Rates that divide the reference exactly separate the exact-quotient exit. Rates above the reference separate the clamp. Rates whose remainder is tiny drive the C-overflow exit with both outcomes of the extra (A-1, 1, 1) test. A sweep of irregular rates is compared against an independent model of the bounded walk, which separates the C versus C+1 ordering, the strict-improvement rule and early termination. A start issued mid-search and long idle waits after completion tell apart the sampling and holding behaviour of done and the outputs.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

  // operand selection for the shared divider
  typedef enum logic [1:0] {
    OP_A    = 2'd0,  // ref / requested rate
    OP_C    = 2'd1,  // (B+1)*rate / (ref - rate*A)
    OP_RATE = 2'd2   // ref*(C+1) / (A*(C+1)+B+1)
  } divOpE;

  // which candidate triple is loaded for evaluation
  typedef enum logic [2:0] {
    SEL_MAXA  = 3'd0,  // (Amax, 1, 1)
    SEL_AM1   = 3'd1,  // (A-1, 1, 1)
    SEL_COVF  = 3'd2,  // (A, B, Cmax)
    SEL_CVAL  = 3'd3,  // (A, B, C)
    SEL_CPLUS = 3'd4   // (A, B, C+1)
  } candSelE;

  typedef struct packed {
    logic    loadReq;
    logic    divStart;
    divOpE   divOp;
    logic    latchA;
    logic    latchC;
    logic    candLoad;
    candSelE candSel;
    logic    compare;
    logic    nextB;
  } dpCtrlT;

  typedef struct packed {
    logic divDone;
    logic aBig;
    logic exactHit;
    logic cOvf;
    logic bZero;
    logic bLast;
    logic errZero;
  } dpStatT;

endpackage

// File: rtl/clkdiv_divider.sv
module clkdiv_divider #(
  parameter int DW = 56
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvdQ;
  logic [DW-1:0] dvsQ;
  logic [DW-1:0] remQ;
  logic [CW-1:0] cntQ;
  logic          busyQ;
  logic [DW:0]   remShift;
  logic          fits;

  // one quotient bit per cycle: shift in the next dividend bit, try to subtract
  assign remShift = {remQ, dvdQ[DW-1]};
  assign fits     = remShift >= {1'b0, dvsQ};
  assign quotient = dvdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      dvdQ  <= '0;
      dvsQ  <= '0;
      remQ  <= '0;
      cntQ  <= '0;
      busyQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busyQ) begin
        dvdQ  <= dividend;
        dvsQ  <= divisor;
        remQ  <= '0;
        cntQ  <= CW'(DW);
        busyQ <= 1'b1;
      end else if (busyQ) begin
        remQ <= fits ? DW'(remShift - {1'b0, dvsQ}) : DW'(remShift);
        dvdQ <= {dvdQ[DW-2:0], fits};
        cntQ <= cntQ - 1'b1;
        if (cntQ == CW'(1)) begin
          busyQ <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R4: a finished quotient is only announced after an active run
  p_div_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busyQ));
  // R4: an accepted start always begins a run
  p_div_start_runs_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busyQ) |=> busyQ);

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_search_pkg::*;
#(
  parameter int unsigned REF_HZ = 66_666_666,
  parameter int          RATE_W = 32,
  parameter int          A_W    = 10,
  parameter int          B_W    = 10,
  parameter int          C_W    = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpCtrlT                   ctl,
  input  logic [RATE_W-1:0]        reqRate,
  output dpStatT                   stat,
  output logic [A_W+B_W+C_W-1:0]   bestWord,
  output logic [RATE_W-1:0]        bestRate
);
  localparam int DW = RATE_W + A_W + C_W + 2;
  localparam logic [RATE_W-1:0] REF_V = RATE_W'(REF_HZ);
  localparam logic [A_W-1:0]    A_MAX = '1;
  localparam logic [B_W-1:0]    B_MAX = '1;
  localparam logic [C_W-1:0]    C_MAX = '1;
  localparam logic [DW-1:0]     C_LIM = DW'(1) << C_W;

  logic [RATE_W-1:0] tgtRate;
  logic [A_W-1:0]    aVal;
  logic [B_W-1:0]    bVal;
  logic [C_W-1:0]    cVal;
  logic              aBig;
  logic              cOvf;
  logic              errZero;
  logic [A_W-1:0]    candA;
  logic [B_W-1:0]    candB;
  logic [C_W-1:0]    candC;
  logic [RATE_W-1:0] bestErr;

  logic [DW-1:0]     divNum;
  logic [DW-1:0]     divDen;
  logic [DW-1:0]     quot;
  logic              divDone;

  logic [A_W-1:0]    nxtA;
  logic [B_W-1:0]    nxtB;
  logic [C_W-1:0]    nxtC;
  logic [RATE_W-1:0] newRate;
  logic [RATE_W-1:0] newErr;

  // divider operand selection
  always_comb begin
    divNum = DW'(REF_V);
    divDen = DW'(reqRate);
    unique case (ctl.divOp)
      OP_C: begin
        divNum = (DW'(bVal) + DW'(1)) * DW'(tgtRate);
        divDen = DW'(REF_V) - DW'(tgtRate) * DW'(aVal);
      end
      OP_RATE: begin
        divNum = DW'(REF_V) * (DW'(candC) + DW'(1));
        divDen = DW'(candA) * (DW'(candC) + DW'(1)) + DW'(candB) + DW'(1);
      end
      default: begin
        divNum = DW'(REF_V);
        divDen = DW'(reqRate);
      end
    endcase
  end

  clkdiv_divider #(.DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (ctl.divStart),
    .dividend (divNum),
    .divisor  (divDen),
    .quotient (quot),
    .done     (divDone)
  );

  // candidate triple chosen by the controller
  always_comb begin
    nxtA = aVal;
    nxtB = bVal;
    nxtC = cVal;
    unique case (ctl.candSel)
      SEL_MAXA:  begin nxtA = A_MAX;       nxtB = B_W'(1); nxtC = C_W'(1); end
      SEL_AM1:   begin nxtA = aVal - 1'b1; nxtB = B_W'(1); nxtC = C_W'(1); end
      SEL_COVF:  nxtC = C_MAX;
      SEL_CPLUS: nxtC = cVal + 1'b1;
      default:   nxtC = cVal;
    endcase
  end

  assign newRate = quot[RATE_W-1:0];
  assign newErr  = (newRate >= tgtRate) ? newRate - tgtRate : tgtRate - newRate;

  assign stat.divDone  = divDone;
  assign stat.aBig     = aBig;
  assign stat.exactHit = (DW'(tgtRate) * DW'(aVal)) == DW'(REF_V);
  assign stat.cOvf     = cOvf;
  assign stat.bZero    = (bVal == '0);
  assign stat.bLast    = (bVal == B_MAX);
  assign stat.errZero  = errZero;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgtRate  <= '0;
      aVal     <= '0;
      bVal     <= '0;
      cVal     <= '0;
      aBig     <= 1'b0;
      cOvf     <= 1'b0;
      errZero  <= 1'b0;
      candA    <= '0;
      candB    <= '0;
      candC    <= '0;
      bestErr  <= '1;
      bestRate <= '0;
      bestWord <= '0;
    end else begin
      if (ctl.loadReq) begin
        tgtRate  <= reqRate;
        bestErr  <= '1;
        bestRate <= '0;
        bestWord <= '0;
        errZero  <= 1'b0;
      end
      if (ctl.latchA) begin
        bVal <= '0;
        aBig <= quot > DW'(A_MAX);
        if (quot == '0) begin
          aVal    <= A_W'(1);
          tgtRate <= REF_V;
        end else begin
          aVal <= A_W'(quot);
        end
      end
      if (ctl.latchC) begin
        cVal <= C_W'(quot - DW'(1));
        cOvf <= (quot == '0) || (quot >= C_LIM);
      end
      if (ctl.nextB) begin
        bVal <= bVal + 1'b1;
      end
      if (ctl.candLoad) begin
        candA <= nxtA;
        candB <= nxtB;
        candC <= nxtC;
      end
      if (ctl.compare) begin
        errZero <= (newErr == '0);
        if (newErr < bestErr) begin
          bestErr  <= newErr;
          bestRate <= newRate;
          bestWord <= {candA, candB, candC};
        end
      end
    end
  end

  // R5: the best error never grows within a search
  p_best_err_falls_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadReq |=> (bestErr <= $past(bestErr)));
  // R10: the target only moves at an accepted start or at the clamp
  p_tgt_held_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadReq && !ctl.latchA) |=> $stable(tgtRate));

endmodule

// File: rtl/clkdiv_control.sv
module clkdiv_control
  import clkdiv_search_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  dpStatT stat,
  output dpCtrlT ctl,
  output logic   done
);
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_A, S_SETUP, S_WAIT_C, S_CHK_C,
    S_EVAL_GO, S_WAIT_R, S_DECIDE, S_NEXT_C
  } stateE;

  // what follows once the candidate under test has been scored
  typedef enum logic [1:0] {K_FINISH, K_B0LOW, K_C0, K_C1} kindE;

  stateE stateQ, nextState;
  kindE  kindQ, nextKind;
  logic  doneQ;
  logic  finish;

  always_comb begin
    ctl       = '0;
    nextState = stateQ;
    nextKind  = kindQ;
    finish    = 1'b0;
    unique case (stateQ)
      S_IDLE: if (start) begin
        ctl.loadReq  = 1'b1;
        ctl.divStart = 1'b1;
        ctl.divOp    = OP_A;
        nextState    = S_WAIT_A;
      end
      S_WAIT_A: if (stat.divDone) begin
        ctl.latchA = 1'b1;
        nextState  = S_SETUP;
      end
      S_SETUP: begin
        if (stat.aBig) begin
          ctl.candLoad = 1'b1;
          ctl.candSel  = SEL_MAXA;
          nextKind     = K_FINISH;
          nextState    = S_EVAL_GO;
        end else if (stat.exactHit) begin
          ctl.candLoad = 1'b1;
          ctl.candSel  = SEL_AM1;
          nextKind     = K_FINISH;
          nextState    = S_EVAL_GO;
        end else begin
          ctl.divStart = 1'b1;
          ctl.divOp    = OP_C;
          nextState    = S_WAIT_C;
        end
      end
      S_WAIT_C: if (stat.divDone) begin
        ctl.latchC = 1'b1;
        nextState  = S_CHK_C;
      end
      S_CHK_C: begin
        ctl.candLoad = 1'b1;
        nextState    = S_EVAL_GO;
        if (stat.cOvf && stat.bZero) begin
          ctl.candSel = SEL_AM1;
          nextKind    = K_B0LOW;
        end else if (stat.cOvf) begin
          ctl.candSel = SEL_COVF;
          nextKind    = K_FINISH;
        end else begin
          ctl.candSel = SEL_CVAL;
          nextKind    = K_C0;
        end
      end
      S_EVAL_GO: begin
        ctl.divStart = 1'b1;
        ctl.divOp    = OP_RATE;
        nextState    = S_WAIT_R;
      end
      S_WAIT_R: if (stat.divDone) begin
        ctl.compare = 1'b1;
        nextState   = S_DECIDE;
      end
      S_DECIDE: begin
        if (stat.errZero || kindQ == K_FINISH) begin
          finish    = 1'b1;
          nextState = S_IDLE;
        end else if (kindQ == K_B0LOW) begin
          ctl.candLoad = 1'b1;
          ctl.candSel  = SEL_COVF;
          nextKind     = K_FINISH;
          nextState    = S_EVAL_GO;
        end else if (kindQ == K_C0) begin
          ctl.candLoad = 1'b1;
          ctl.candSel  = SEL_CPLUS;
          nextKind     = K_C1;
          nextState    = S_EVAL_GO;
        end else if (stat.bLast) begin
          finish    = 1'b1;
          nextState = S_IDLE;
        end else begin
          ctl.nextB = 1'b1;
          nextState = S_NEXT_C;
        end
      end
      S_NEXT_C: begin
        ctl.divStart = 1'b1;
        ctl.divOp    = OP_C;
        nextState    = S_WAIT_C;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      kindQ  <= K_FINISH;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= nextState;
      kindQ  <= nextKind;
      if (finish) begin
        doneQ <= 1'b1;
      end else if (start && stateQ == S_IDLE) begin
        doneQ <= 1'b0;
      end
    end
  end

  assign done = doneQ;

  // R9: done persists while no start arrives
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (doneQ && !start) |=> doneQ);
  // R9: an accepted start drops done at once
  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (start && stateQ == S_IDLE) |=> !doneQ);
  // R10: done is never shown while a search is in flight
  p_busy_not_done_r10: assert property (@(posedge clk) disable iff (rst)
    (stateQ != S_IDLE) |-> !doneQ);

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_search_pkg::*;
#(
  parameter int unsigned REF_HZ = 66_666_666,
  parameter int          RATE_W = 32,
  parameter int          A_W    = 10,
  parameter int          B_W    = 10,
  parameter int          C_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [RATE_W-1:0]      reqRate,
  output logic [A_W+B_W+C_W-1:0] ctrlWord,
  output logic [RATE_W-1:0]      achievedRate,
  output logic                   done
);
  dpCtrlT ctl;
  dpStatT stat;

  clkdiv_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .done  (done)
  );

  clkdiv_datapath #(
    .REF_HZ (REF_HZ),
    .RATE_W (RATE_W),
    .A_W    (A_W),
    .B_W    (B_W),
    .C_W    (C_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reqRate  (reqRate),
    .stat     (stat),
    .bestWord (ctrlWord),
    .bestRate (achievedRate)
  );

endmodule

// File: tb/sim_clkdiv_search.sv
module sim_clkdiv_search;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned REF = 1_000_000;
  localparam int RW = 21;
  localparam int AW = 6;
  localparam int BW = 5;
  localparam int CWD = 7;
  localparam int WW = AW + BW + CWD;
  localparam longint AMAX = (64'd1 << AW) - 1;
  localparam longint BMAX = (64'd1 << BW) - 1;
  localparam longint CMAX = (64'd1 << CWD) - 1;
  localparam int NSWEEP = 12;
  localparam int unsigned SWEEP [NSWEEP] = '{
    16000, 21000, 33333, 47000, 77777, 99999,
    123456, 180000, 287001, 512345, 700001, 950000 };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [RW-1:0] reqRate = '0;
  logic [WW-1:0] ctrlWord;
  logic [RW-1:0] achievedRate;
  logic          done;

  int nChecks = 0;
  int nFail = 0;

  longint mTgt, mBestErr, mBestRate, mBestWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_search #(.REF_HZ(REF), .RATE_W(RW), .A_W(AW), .B_W(BW), .C_W(CWD)) u0 (
    .clk(clk), .rst(rst), .start(start), .reqRate(reqRate),
    .ctrlWord(ctrlWord), .achievedRate(achievedRate), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model of the bounded search
  function automatic longint evalCand(input longint a, input longint b, input longint c);
    longint nr, d;
    nr = (longint'(REF) * (c + 1)) / (a * (c + 1) + b + 1);
    d  = (nr > mTgt) ? nr - mTgt : mTgt - nr;
    if (d < mBestErr) begin
      mBestErr  = d;
      mBestRate = nr;
      mBestWord = (a << (BW + CWD)) | (b << CWD) | c;
    end
    return d;
  endfunction

  function automatic void model(input longint r);
    longint a, q, c;
    mTgt = r; mBestErr = (64'd1 << RW) - 1; mBestRate = 0; mBestWord = 0;
    a = longint'(REF) / r;
    if (a > AMAX) begin void'(evalCand(AMAX, 1, 1)); return; end
    if (a == 0) begin a = 1; mTgt = REF; end
    if (mTgt * a == longint'(REF)) begin void'(evalCand(a - 1, 1, 1)); return; end
    for (longint b = 0; b <= BMAX; b++) begin
      q = ((b + 1) * mTgt) / (longint'(REF) - mTgt * a);
      c = q - 1;
      if (q == 0 || c >= CMAX) begin
        if (b == 0 && evalCand(a - 1, 1, 1) == 0) return;
        void'(evalCand(a, b, CMAX));
        return;
      end
      if (evalCand(a, b, c) == 0) return;
      if (evalCand(a, b, c + 1) == 0) return;
    end
  endfunction

  task automatic runSearch(input longint r, output longint w, output longint ar);
    int cnt;
    @(negedge clk);
    start = 1'b1; reqRate = RW'(r);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 30000) begin @(negedge clk); cnt++; end
    if (!done) chk(1'b0, "R9 search timeout", 0, 1);
    w = longint'(ctrlWord); ar = longint'(achievedRate);
  endtask

  task automatic directed(input longint r, input longint ew, input longint er, input string req);
    longint w, ar;
    runSearch(r, w, ar);
    chk(w == ew, req, w, ew);
    chk(ar == er, req, ar, er);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    longint w, ar, w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(done == 1'b0, "R11 done after reset", done, 0);
    chk(ctrlWord == '0, "R11 word after reset", ctrlWord, 0);
    chk(achievedRate == '0, "R11 rate after reset", achievedRate, 0);

    // sweep against the model: R4 R5 R6 R8
    for (int i = 0; i < NSWEEP; i++) begin
      model(SWEEP[i]);
      runSearch(SWEEP[i], w, ar);
      chk(w == mBestWord, "R6 R8 sweep word", w, mBestWord);
      chk(ar == mBestRate, "R4 R5 sweep rate", ar, mBestRate);
    end

    // R1: quotient above the largest A -> (63,1,1), 2e6/128
    directed(10000, 258177, 15625, "R1 A saturation");
    // R3: exact quotient -> (3,1,1)
    directed(250000, 12417, 250000, "R3 exact divide");
    // R2: rate above ref clamps -> (0,1,1) at ref
    directed(1500000, 129, 1000000, "R2 clamp to ref");
    directed(1000000, 129, 1000000, "R3 rate equals ref");
    // R6: first C candidate hits -> (2,0,1)
    directed(400000, 8193, 400000, "R6 first C exact");
    // R7: overflow at B=0 with exact (A-1,1,1) -> (2,1,1)
    directed(333333, 8321, 333333, "R7 overflow low hit");
    // R7: overflow at B=0, (4,1,1) beats (5,0,127)
    directed(199999, 16513, 200000, "R7 overflow fallback");

    // R9: done and outputs hold while idle
    w0 = longint'(ctrlWord);
    repeat (30) @(negedge clk);
    chk(done == 1'b1, "R9 done held", done, 1);
    chk(longint'(ctrlWord) == w0, "R9 word held", ctrlWord, w0);

    // R9 and R10: start clears done; a second start mid-search is ignored
    model(300000);
    @(negedge clk);
    start = 1'b1; reqRate = RW'(300000);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9 done cleared by start", done, 0);
    repeat (4) @(negedge clk);
    start = 1'b1; reqRate = RW'(10000);
    @(negedge clk);
    start = 1'b0; reqRate = RW'(777);
    for (int k = 0; k < 30000 && !done; k++) @(negedge clk);
    chk(longint'(ctrlWord) == mBestWord, "R10 ignored start word", ctrlWord, mBestWord);
    chk(longint'(achievedRate) == mBestRate, "R10 ignored start rate", achievedRate, mBestRate);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule